// File: doc/BRIEF.md
# Flash Access Violation Checker

This block watches every access that reaches the on-chip flash and decides whether that access is allowed. An access can be an instruction fetch, a data read, a write or a page erase. Each access is compared against a parameterised top address for user code. When a lock is enabled, each access is also compared against a lock-page boundary. An access that breaks a rule produces a one-cycle system reset request. The same access also sets a sticky error flag. Software can read that flag after the reset to find out why the chip restarted.

The classification is purely combinational on the access strobe. The reset request and the error flag are registered, so both change on the clock edge that follows the offending access. The flag survives the reset that the block itself requested, which the reset controller reports through a qualifier. A system reset from any other cause clears the flag. The external reset pin is never driven by this block.

Top module: `flash_guard`

## Requirements
- R1: An instruction fetch (class code 0) from an address strictly above CODE_LIMIT is a violation. A fetch at or below CODE_LIMIT is legal, including a fetch from a locked page.
- R2: A data read (class code 1) from an address strictly above CODE_LIMIT is a violation.
- R3: A write (class code 2) or erase (class code 3) to an address strictly above CODE_LIMIT is a violation.
- R4: With lockEn high, a write or erase whose page number (address shifted right by PAGE_SHIFT) is greater than or equal to lockPage is a violation.
- R5: With lockEn high, a data read from a locked page is a violation unless fetchPc also lies in a locked page.
- R6: An address exactly equal to CODE_LIMIT is legal for every class.
- R7: reqReset is high for exactly the one cycle that follows each clock cycle in which a violating access is presented with accValid high. It stays low after cycles with accValid low or with a legal access.
- R8: flashErr goes high together with reqReset. It then holds until a clearing reset, including across a resetEvent that has resetByFlash high.
- R9: A resetEvent with resetByFlash low clears flashErr on the next edge. If a violating access arrives in the same cycle, the flag is set instead.
- R10: rstN low asynchronously forces reqReset and flashErr low.
- R11: With lockEn low, the lock rules of R4 and R5 have no effect; only the limit check applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| accValid | input | 1 | An access is presented this cycle |
| accType | input | 2 | Access class: 0 fetch, 1 read, 2 write, 3 erase |
| accAddr | input | ADDR_W | Target flash address |
| fetchPc | input | ADDR_W | Address of the code issuing a data read |
| lockEn | input | 1 | Security lock active |
| lockPage | input | ADDR_W-PAGE_SHIFT | First locked page; all pages at or above it are locked |
| resetEvent | input | 1 | A system reset is being applied this cycle |
| resetByFlash | input | 1 | The reset in progress was requested by this block |
| reqReset | output | 1 | One-cycle system reset request |
| flashErr | output | 1 | Sticky flash-error flag |

## Verification
The flag-set path and the flag-clear path can both act in the same cycle: a violating access can arrive while a reset from another cause is being applied. The bench forces this by raising resetEvent, with resetByFlash low, during a write above the limit. It expects the flag to stay set and a request to follow one cycle later. The bench also replays the case where the flag should survive: a reset qualified as caused by this block, applied while idle. A behavioural model predicts both outputs on every clock.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_ERASE = 2'd3
  } accClass_t;

  // Comparator results, datapath to control
  typedef struct packed {
    logic overLimit;
    logic addrLocked;
    logic pcLocked;
  } fgFlags_t;

  // Strobes, control to datapath
  typedef struct packed {
    logic fire;
    logic clrErr;
  } fgStrobes_t;
endpackage

// File: rtl/fg_control.sv
module fg_control
  import fg_pkg::*;
(
  input  logic       accValid,
  input  accClass_t  accClass,
  input  fgFlags_t   flags,
  input  logic       resetEvent,
  input  logic       resetByFlash,
  output fgStrobes_t str
);
  logic bad;

  always_comb begin
    unique case (accClass)
      ACC_FETCH: bad = flags.overLimit;
      ACC_READ:  bad = flags.overLimit | (flags.addrLocked & ~flags.pcLocked);
      default:   bad = flags.overLimit | flags.addrLocked;
    endcase
    str.fire   = accValid & bad;
    str.clrErr = resetEvent & ~resetByFlash;
  end
endmodule

// File: rtl/fg_datapath.sv
module fg_datapath
  import fg_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          PAGE_SHIFT = 9,
  parameter logic [15:0] CODE_LIMIT = 16'h7BFF
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         accValid,
  input  accClass_t                    accClass,
  input  logic [ADDR_W-1:0]            accAddr,
  input  logic [ADDR_W-1:0]            fetchPc,
  input  logic                         lockEn,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] lockPage,
  input  logic                         resetEvent,
  input  logic                         resetByFlash,
  input  fgStrobes_t                   str,
  output fgFlags_t                     flags,
  output logic                         reqReset,
  output logic                         flashErr
);
  localparam int PAGE_W = ADDR_W - PAGE_SHIFT;
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(CODE_LIMIT);

  logic [PAGE_W-1:0] addrPage, pcPage;

  assign addrPage         = accAddr[ADDR_W-1:PAGE_SHIFT];
  assign pcPage           = fetchPc[ADDR_W-1:PAGE_SHIFT];
  assign flags.overLimit  = accAddr > LIMIT;
  assign flags.addrLocked = lockEn && (addrPage >= lockPage);
  assign flags.pcLocked   = lockEn && (pcPage >= lockPage);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqReset <= 1'b0;
      flashErr <= 1'b0;
    end else begin
      reqReset <= str.fire;
      if (str.fire)        flashErr <= 1'b1;
      else if (str.clrErr) flashErr <= 1'b0;
    end
  end

  AST_FETCH_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    accValid && accClass == ACC_FETCH && accAddr > LIMIT |=> reqReset); // R1
  AST_READ_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    accValid && accClass == ACC_READ && accAddr > LIMIT |=> reqReset); // R2
  AST_WRITE_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    accValid && accClass[1] && accAddr > LIMIT |=> reqReset); // R3
  AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    accValid && accClass[1] && lockEn && (accAddr >> PAGE_SHIFT) >= ADDR_W'(lockPage) |=> reqReset); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> !reqReset); // R7
  AST_REQ_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    reqReset |-> flashErr); // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    flashErr && !resetEvent |=> flashErr); // R8
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    resetEvent && !resetByFlash && !accValid |=> !flashErr); // R9
  AST_NO_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    accValid && !lockEn && accAddr <= LIMIT |=> !reqReset); // R11
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fg_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          PAGE_SHIFT = 9,
  parameter logic [15:0] CODE_LIMIT = 16'h7BFF
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         accValid,
  input  logic [1:0]                   accType,
  input  logic [ADDR_W-1:0]            accAddr,
  input  logic [ADDR_W-1:0]            fetchPc,
  input  logic                         lockEn,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] lockPage,
  input  logic                         resetEvent,
  input  logic                         resetByFlash,
  output logic                         reqReset,
  output logic                         flashErr
);
  accClass_t  accClass;
  fgFlags_t   flags;
  fgStrobes_t str;

  assign accClass = accClass_t'(accType);

  fg_control u_ctrl (
    .accValid    (accValid),
    .accClass    (accClass),
    .flags       (flags),
    .resetEvent  (resetEvent),
    .resetByFlash(resetByFlash),
    .str         (str)
  );

  fg_datapath #(
    .ADDR_W    (ADDR_W),
    .PAGE_SHIFT(PAGE_SHIFT),
    .CODE_LIMIT(CODE_LIMIT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .accValid    (accValid),
    .accClass    (accClass),
    .accAddr     (accAddr),
    .fetchPc     (fetchPc),
    .lockEn      (lockEn),
    .lockPage    (lockPage),
    .resetEvent  (resetEvent),
    .resetByFlash(resetByFlash),
    .str         (str),
    .flags       (flags),
    .reqReset    (reqReset),
    .flashErr    (flashErr)
  );
endmodule

// File: tb/flash_guard_tb.sv
module flash_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int PS = 9;
  localparam int LIMIT = 'h7BFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 1'b0;
  logic [1:0] accType = 2'd0;
  logic [AW-1:0] accAddr = '0;
  logic [AW-1:0] fetchPc = '0;
  logic lockEn = 1'b0;
  logic [AW-PS-1:0] lockPage = '0;
  logic resetEvent = 1'b0;
  logic resetByFlash = 1'b0;
  logic reqReset, flashErr;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  string curTag = "R10";
  string expTag = "R10";
  bit expReq = 0;
  bit expErr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_guard dut_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accType(accType),
    .accAddr(accAddr), .fetchPc(fetchPc), .lockEn(lockEn), .lockPage(lockPage),
    .resetEvent(resetEvent), .resetByFlash(resetByFlash),
    .reqReset(reqReset), .flashErr(flashErr)
  );

  // Behavioural rule set, written from the requirements
  function automatic bit violates(int t, int a, int pc, bit le, int lp);
    int pageSize = 1 << PS;
    bit over = a > LIMIT;
    bit aLock = le && (a / pageSize) >= lp;
    bit pLock = le && (pc / pageSize) >= lp;
    if (t == 0) return over;
    if (t == 1) return over || (aLock && !pLock);
    return over || aLock;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expReq <= 0; expErr <= 0; expTag <= "R10";
    end else begin
      bit bad;
      bad = accValid && violates(int'(accType), int'(accAddr), int'(fetchPc), lockEn, int'(lockPage));
      expReq <= bad;
      if (bad) expErr <= 1;
      else if (resetEvent && !resetByFlash) expErr <= 0;
      expTag <= curTag;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      compared++;
      if (reqReset !== expReq || flashErr !== expErr) begin
        mismatched++;
        $display("FAIL %s: reqReset=%0b flashErr=%0b expected reqReset=%0b flashErr=%0b at %0t",
                 expTag, reqReset, flashErr, expReq, expErr, $time);
      end
    end
  end

  task automatic step(bit v, int t, int a, int pc, string tag);
    @(negedge clk);
    #1;
    accValid = v; accType = 2'(t); accAddr = AW'(a); fetchPc = AW'(pc);
    curTag = tag;
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);                         // R10 reset state compared
    rstN = 1'b1;
    step(1, 0, 'h0100, 0, "R1");                       // legal fetch
    step(1, 0, LIMIT, 0, "R6");                        // fetch at limit
    step(1, 1, LIMIT, 0, "R6");
    step(1, 2, LIMIT, 0, "R6");
    step(1, 0, LIMIT + 1, 0, "R1");                    // fetch past limit
    idle("R7");
    idle("R8");
    step(1, 1, 'hFFFF, 0, "R2");
    idle("R7");
    step(1, 2, 'h7C00, 0, "R3");
    step(1, 3, 'hA000, 0, "R3");                       // back-to-back violations
    idle("R7");
    // foreign reset clears flag (R9)
    @(negedge clk); #1; resetEvent = 1; resetByFlash = 0; curTag = "R9";
    @(negedge clk); #1; resetEvent = 0; curTag = "R9";
    step(1, 3, 'h7E00, 0, "R3");
    // self-caused reset keeps flag (R8)
    @(negedge clk); #1; accValid = 0; resetEvent = 1; resetByFlash = 1; curTag = "R8";
    @(negedge clk); #1; resetEvent = 0; resetByFlash = 0; curTag = "R8";
    idle("R8");
    @(negedge clk); #1; resetEvent = 1; curTag = "R9";
    @(negedge clk); #1; resetEvent = 0;
    // lock rules, lock starts at page 0x30 = address 0x6000
    lockEn = 1; lockPage = 7'h30;
    step(1, 2, 'h6000, 0, "R4");
    step(1, 3, 'h7A00, 0, "R4");
    step(1, 2, 'h5FFF, 0, "R4");                       // just below lock, legal
    step(1, 1, 'h6800, 'h1000, "R5");                  // read from outside
    step(1, 1, 'h6800, 'h6100, "R5");                  // read from locked code
    step(1, 0, 'h6400, 0, "R1");                       // fetch in locked page
    idle("R7");
    // violation and foreign reset in same cycle (R9)
    @(negedge clk); #1; resetEvent = 1; resetByFlash = 0;
    accValid = 1; accType = 2; accAddr = 'h8000; curTag = "R9";
    @(negedge clk); #1; resetEvent = 0; accValid = 0; curTag = "R9";
    idle("R8");
    // lock disabled (R11)
    lockEn = 0;
    @(negedge clk); #1; resetEvent = 1; curTag = "R9";
    @(negedge clk); #1; resetEvent = 0;
    step(1, 2, 'h6000, 0, "R11");
    step(1, 1, 'h7000, 'h0000, "R11");
    idle("R11");
    // mixed sweep
    lockEn = 1; lockPage = 7'h20;
    for (int i = 0; i < 300; i++) begin
      step(((i % 5) != 0), i % 4, (i * 1237) & 'hFFFF, (i * 331) & 'hFFFF, "R7");
      if ((i % 37) == 0) begin
        @(negedge clk); #1; accValid = 0; resetEvent = 1; resetByFlash = (i % 2); curTag = "R9";
        @(negedge clk); #1; resetEvent = 0; resetByFlash = 0;
      end
    end
    // async reset while flag is set (R10)
    step(1, 0, 'hF000, 0, "R1");
    idle("R8");
    #2; rstN = 0;
    @(negedge clk); #1;
    @(negedge clk); #1; rstN = 1; curTag = "R7";
    idle("R7");
    idle("R7");
    @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule